// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the device side of a two-wire serial memory. It works entirely in the system clock domain. A short synchroniser oversamples the bus clock and data lines. The block recognises start and stop conditions and checks each incoming device byte against the hard-wired select pins. It acknowledges every accepted byte by pulling the data line low through an open-drain enable.

Writes are collected in a page buffer. The buffer is copied into a register-array memory only when a stop closes the transfer at a byte boundary. A self-timed busy period follows each commit. During that period the block answers nothing, so a host can poll for completion by repeatedly sending its device byte.

Reads take three forms:
- a current-address read, which uses an internal pointer;
- a random read, which is a write that carries only a word address, followed by a repeated start;
- a sequential read, which continues for as long as the host acknowledges.

The memory size is a parameter from 128 to 2048 bytes. The size sets the page length and decides how many of the three select bits are compared and how many act as upper memory address bits.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the open-drain enable is released, every memory byte reads 0x00 and the address pointer is 0.
- R2: A device byte whose upper nibble is 1010 and whose compared select bits match the pins is acknowledged by driving the line low during the ninth clock. Bit 0 of the device byte is 1 for read and 0 for write. Any other device byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: The select bits are bits 3..1 of the device byte, matched against pins 2..0. With a memory of 256 bytes or fewer, all three bits are compared. Above 256 bytes, the lowest log2(size)-8 of these bits are not compared and instead become the upper bits of the word address. For example, at 512 bytes bit 1 is address bit 8 and pin 0 is ignored.
- R4: A write carries the device byte, one word-address byte, then data bytes, and is closed by a stop. Data bytes land at successive addresses. The low page-offset bits of the address wrap inside the page, so a later byte overwrites an earlier one at the same offset. The page holds 8 bytes for sizes up to 256 and 16 bytes above that.
- R5: A stop or start that arrives after one or more data bits of an unfinished byte discards the whole write. Nothing is committed and no busy period starts.
- R6: A committed write starts a busy period of WRITE_CYCLES system clocks. During it no device byte is acknowledged. After it the device byte is acknowledged again.
- R7: While the write-protect input is high at the stop, the memory is left unchanged and no busy period starts.
- R8: The pointer holds the address after the last byte accessed. A current-address read returns the byte there, and reading wraps from the last byte of the array to byte 0.
- R9: A random read (device byte W, word address, repeated start, device byte R) returns the data at the loaded address.
- R10: While the host acknowledges, the block sends the following bytes in turn. After a host non-acknowledge it releases the line and stays released until the next start.
- R11: The block changes its data-line enable only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin (wired-AND level) |
| pin_sel | input | 3 | Hard-wired select pins, bit 2 compared first |
| wp_i | input | 1 | Write protect, high blocks commits |
| sda_oe | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The assertions assume a well-behaved host. The host changes the data line only while the bus clock is low, except for start and stop. It never issues a start or stop while the block holds the line low. It holds every bus level for longer than the two-stage synchroniser delay. The bench drives each bus phase for at least five system clocks. It moves the data line a full quarter period after the clock falls and releases the line during every acknowledge and read slot. As a result, edges on the wired bus always reach the block one at a time and in legal order.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int MEM_BYTES    = 512,
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] pin_sel,
  input  logic       wp_i,
  output logic       sda_oe
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PB  = (MEM_BYTES <= 256) ? 8 : 16;
  localparam int PW  = $clog2(PB);
  localparam int EXT = (AW > 8) ? AW - 8 : 0;
  localparam int WCW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_DEV, K_WORD, K_DATA} kind_t;

  logic [2:0] scl_r, sda_r;
  st_t        st;
  kind_t      kind;
  logic [3:0] bitc;
  logic [7:0] sh;
  logic [AW-1:0] ptr;
  logic [2:0] ext_q;
  logic       rd, mack_ok;
  logic [WCW-1:0] busy_cnt;
  logic [7:0] mem   [MEM_BYTES];
  logic [7:0] buf_d [PB];
  logic [PB-1:0] buf_v;

  wire scl_q     = scl_r[1];
  wire sda_q     = sda_r[1];
  wire scl_rise  = scl_r[1] & ~scl_r[2];
  wire scl_fall  = ~scl_r[1] & scl_r[2];
  wire start_det = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop_det  = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
  wire busy      = busy_cnt != '0;

  logic pin_ok;
  always_comb begin
    pin_ok = 1'b1;
    for (int i = 0; i < 3; i++)
      if (i >= EXT && sh[i+1] != pin_sel[i]) pin_ok = 1'b0;
  end

  wire [2:0]  ext_used  = ext_q & 3'((1 << EXT) - 1);
  wire [10:0] full_addr = {ext_used, sh};
  wire [AW-1:0] ptr_load = full_addr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_DEV;
      bitc     <= '0;
      sh       <= '0;
      ptr      <= '0;
      ext_q    <= '0;
      rd       <= 1'b0;
      mack_ok  <= 1'b0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
      buf_v    <= '0;
      for (int i = 0; i < PB; i++) buf_d[i] <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      st       <= S_IDLE;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_DEV;
      bitc   <= '0;
      sda_oe <= 1'b0;
      buf_v  <= '0;
    end else if (stop_det) begin
      if (st == S_RX && kind == K_DATA && bitc <= 4'd1 && |buf_v && !wp_i) begin
        for (int i = 0; i < PB; i++)
          if (buf_v[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= buf_d[i];
        busy_cnt <= WCW'(WRITE_CYCLES);
      end
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      buf_v  <= '0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitc < 4'd8) begin
            sh   <= {sh[6:0], sda_q};
            bitc <= bitc + 1'b1;
          end else if (scl_fall && bitc == 4'd8) begin
            case (kind)
              K_DEV: begin
                if (sh[7:4] == 4'b1010 && pin_ok) begin
                  sda_oe <= 1'b1;
                  st     <= S_ACK;
                  rd     <= sh[0];
                  if (!sh[0]) ext_q <= sh[3:1];
                end else begin
                  st <= S_IDLE;
                end
              end
              K_WORD: begin
                ptr    <= ptr_load;
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end
              default: begin
                buf_d[ptr[PW-1:0]] <= sh;
                buf_v[ptr[PW-1:0]] <= 1'b1;
                ptr[PW-1:0]        <= ptr[PW-1:0] + 1'b1;
                sda_oe             <= 1'b1;
                st                 <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitc <= '0;
            if (kind == K_DEV && rd) begin
              sh     <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              ptr    <= ptr + 1'b1;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == K_DEV) ? K_WORD : K_DATA;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitc <= bitc + 1'b1;
          end else if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_q;
          end else if (scl_fall) begin
            if (mack_ok) begin
              sh     <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              ptr    <= ptr + 1'b1;
              bitc   <= '0;
              st     <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_oe_moves_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);

  a_r2_drive_in_ack_or_tx: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || st == S_TX));

  a_r2_start_arms_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !busy) |=> (st == S_RX && kind == K_DEV && bitc == 4'd0));

  a_r6_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sda_oe);

  a_r6_busy_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt == WCW'(WRITE_CYCLES)) |-> $past(stop_det));
endmodule

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;
  localparam int MB = 512;
  localparam int WC = 400;
  localparam int Q  = 5;
  localparam int H  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int vectors = 0, miscompares = 0, r11_viol = 0;
  logic [7:0] mdl [MB];
  int mptr = 0;

  always #2 clk = ~clk;

  twi_eeprom_slave #(.MEM_BYTES(MB), .WRITE_CYCLES(WC)) i_twi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .pin_sel(pins), .wp_i(wp), .sda_oe(sda_oe));

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && m_scl) r11_viol++;
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
    ack = !sda_bus; tick(H/2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); m_scl = 1'b0; tick(Q);
    end
    m_sda = mack ? 1'b0 : 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input bit p, input bit rdb);
    return {4'b1010, 1'b1, 1'b0, p, rdb};
  endfunction

  task automatic write_txn(input int addr, input int len, output bit ok);
    bit a;
    logic [7:0] d;
    int off;
    ok = 1'b1;
    start_c();
    send_byte(dev(addr[8], 1'b0), a); ok &= a;
    send_byte(addr[7:0], a); ok &= a;
    off = addr % 16;
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      send_byte(d, a); ok &= a;
      if (!wp) mdl[(addr & ~15) | off] = d;
      off = (off + 1) % 16;
    end
    mptr = (addr & ~15) | off;
    stop_c();
  endtask

  task automatic poll(output int n);
    bit a;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      start_c();
      send_byte(dev(1'b0, 1'b0), a);
      stop_c();
      n++;
      if (a) break;
    end
  endtask

  task automatic read_seq(input int len, input string req);
    logic [7:0] b;
    for (int k = 0; k < len; k++) begin
      recv_byte(b, k < len - 1);
      check(b == mdl[mptr], req, b, mdl[mptr]);
      mptr = (mptr + 1) % MB;
    end
  endtask

  task automatic read_rand(input int addr, input int len, input string req);
    bit a;
    start_c();
    send_byte(dev(addr[8], 1'b0), a);
    send_byte(addr[7:0], a);
    start_c();
    send_byte(dev(1'b0, 1'b1), a);
    check(a, "R9 read device byte ack", a, 1);
    mptr = addr;
    read_seq(len, req);
    stop_c();
  endtask

  initial begin
    int n, ad, ln;
    bit ok, a;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    check(sda_oe == 1'b0, "R1 enable released after reset", sda_oe, 0);
    start_c(); send_byte(dev(1'b0, 1'b1), a);
    check(a, "R1 R2 device byte acknowledged", a, 1);
    mptr = 0; read_seq(1, "R1 current read after reset");
    stop_c();

    start_c(); send_byte({4'b1010, 1'b1, 1'b1, 1'b0, 1'b0}, a);
    check(!a, "R2 R3 wrong pin1 select refused", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 ignored until next start", a, 0);
    stop_c();
    start_c(); send_byte({4'b0110, 1'b1, 1'b0, 1'b0, 1'b0}, a);
    check(!a, "R2 wrong upper nibble refused", a, 0);
    stop_c();

    write_txn(9'h1F5, 3, ok);
    check(ok, "R3 R4 write acked with address bit 8 set", ok, 1);
    poll(n);
    check(n > 1, "R6 first poll refused while busy", n, 2);
    check(n < 50, "R6 acknowledged after busy", n, 1);
    read_rand(9'h1F0, 16, "R3 R4 upper-page readback");
    read_rand(9'h0F0, 8, "R3 lower page untouched");

    write_txn(9'h02E, 5, ok);
    poll(n);
    read_rand(9'h020, 16, "R4 page wrap readback");

    start_c(); send_byte(dev(1'b0, 1'b1), a);
    read_seq(2, "R8 current address after read");
    tick(Q);
    check(sda_oe == 1'b0, "R10 released after host nack", sda_oe, 0);
    stop_c();

    wp = 1'b1;
    write_txn(9'h060, 4, ok);
    wp = 1'b0;
    poll(n);
    check(n == 1, "R7 no busy under write protect", n, 1);
    read_rand(9'h060, 4, "R7 memory unchanged");

    start_c();
    send_byte(dev(1'b0, 1'b0), a); send_byte(8'h80, a); send_byte(8'hAA, a);
    send_bits(8'hFF, 4);
    stop_c();
    poll(n);
    check(n == 1, "R5 stop mid-byte: no busy", n, 1);
    read_rand(9'h080, 1, "R5 stop mid-byte: nothing committed");

    start_c();
    send_byte(dev(1'b0, 1'b0), a); send_byte(8'h90, a); send_byte(8'h55, a);
    start_c();
    send_byte(dev(1'b0, 1'b1), a);
    mptr = 9'h091;
    read_seq(1, "R5 R8 start mid-write then current read");
    stop_c();
    read_rand(9'h090, 1, "R5 start mid-write: nothing committed");

    read_rand(MB - 2, 4, "R8 R10 sequential wrap to 0");

    for (int it = 0; it < 8; it++) begin
      ad = int'($urandom % MB);
      ln = 1 + int'($urandom % 18);
      write_txn(ad, ln, ok);
      check(ok, "R4 random write acked", ok, 1);
      poll(n);
      check(n > 1 && n < 50, "R6 random busy window", n, 2);
      ad = int'($urandom % MB);
      ln = 1 + int'($urandom % 12);
      read_rand(ad, ln, "R9 R10 random sequential read");
    end

    check(r11_viol == 0, "R11 enable changed with clock high", r11_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule